// File: doc/BRIEF.md
# Slack-Arm Reference Re-centring Unit

Two H-bridges that share one DC bus have four half-bridge arms, but only three of the arm currents can be controlled independently. Three current controllers each supply a voltage reference, for arms A1, B1 and B2. The fourth arm, A2, carries the slack current and has no controller. This unit gives the slack arm a reference of zero. It then picks one common offset and adds it to all four references. A common offset leaves every arm current unchanged, so the unit can use this freedom to re-centre the references and keep the modulators away from saturation.

The offset can be chosen in two ways, set by a mode input that is sampled together with the input strobe:

- **Centring mode** makes the largest and smallest adjusted references equal in magnitude.
- **Zero-sum mode** makes the four adjusted references sum to roughly zero.

The adjusted references are saturated to the output width. A sticky flag records that any output was ever clipped. Each accepted input produces exactly one result, two clock cycles later.

Top module: `arm_ref_recenter`

## Requirements
- R1: After reset, all four adjusted outputs are 0, `out_valid` is 0 and `clip_flag` is 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid`, two clock edges later. Inputs on consecutive cycles give results on consecutive cycles.
- R3: The slack arm output `adj_a2` equals the common offset. When no output clips, every other output minus its own input reference equals `adj_a2`.
- R4: With `mode_sel` = 0 (centring), the offset is -floor((max+min)/2), where max and min are taken over {ref_a1, ref_b1, 0, ref_b2}. The floor rounds toward negative infinity.
- R5: With `mode_sel` = 1 (zero-sum), the offset is -floor((ref_a1+ref_b1+ref_b2)/4), rounded toward negative infinity.
- R6: `mode_sel` is used only in a cycle where `in_valid` is high. Its value in any other cycle has no effect on later results.
- R7: Each adjusted output saturates to the signed OUT_W range: -2^(OUT_W-1) to 2^(OUT_W-1)-1.
- R8: `clip_flag` goes high with the first result that has any output saturated. It then stays high until reset.
- R9: While `out_valid` is low, the four adjusted outputs hold their last values.
- R10: When no output clips, the adjusted set is balanced:
  - in centring mode, the maximum plus the minimum of the four outputs is 0 or 1;
  - in zero-sum mode, the sum of the four outputs is between 0 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: the three references and the mode are valid this cycle |
| mode_sel | input | 1 | 0 = centring, 1 = zero-sum |
| ref_a1 | input | IN_W | Controller reference for arm A1, signed |
| ref_b1 | input | IN_W | Controller reference for arm B1, signed |
| ref_b2 | input | IN_W | Controller reference for arm B2, signed |
| out_valid | output | 1 | Strobe: the adjusted references are new this cycle |
| adj_a1 | output | OUT_W | Adjusted reference for arm A1, signed |
| adj_b1 | output | OUT_W | Adjusted reference for arm B1, signed |
| adj_a2 | output | OUT_W | Adjusted reference for the slack arm A2 (equals the offset), signed |
| adj_b2 | output | OUT_W | Adjusted reference for arm B2, signed |
| clip_flag | output | 1 | Sticky: some output has been saturated since reset |

## Verification
Each internal fault shows up at the ports two cycles after the input that exposes it.

- **Wrong extreme or wrong rounding shift.** The slack output differs from the hand-computed offset, and the balance property fails. Odd sums with negative sign are used to catch truncation toward zero, which is otherwise easy to miss.
- **Lost or duplicated valid bit.** A missing or repeated `out_valid` pulse appears at the exact sample point.
- **Wrong mode capture.** A mode value taken from a non-valid cycle changes the offset of the next result.
- **Clip-tracking fault.** A non-sticky or missing clip flag is visible on the first clipped result or on the clean result that follows it.

// File: rtl/arm_ref_pkg.sv
// Package: shared constants and types for the arm reference re-centring unit.
// Arm index order is fixed: 0=A1, 1=B1, 2=A2 (slack), 3=B2.
package arm_ref_pkg;

    typedef enum logic {
        MODE_CENTRE  = 1'b0,
        MODE_ZERO_SUM = 1'b1
    } recentre_mode_e;

    localparam int NUM_ARMS  = 4;
    localparam int SLACK_IDX = 2;
    localparam int GUARD_W   = 2;

endpackage

// File: rtl/offset_calc.sv
// offset_calc: first pipeline stage.
// Builds the four-arm set with an implicit zero in the slack slot, finds the
// common offset for the sampled mode, and registers the set and the offset.
// Assumes the input is valid only when in_valid is high; holds its state
// otherwise.
module offset_calc
    import arm_ref_pkg::*;
#(
    parameter int IN_W = 16,
    localparam int SW  = IN_W + GUARD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 mode_sel,
    input  logic signed [IN_W-1:0] ref_a1,
    input  logic signed [IN_W-1:0] ref_b1,
    input  logic signed [IN_W-1:0] ref_b2,
    output logic                 s1_valid,
    output logic signed [IN_W-1:0] s1_ref [NUM_ARMS],
    output logic signed [SW-1:0]   s1_off
);

    logic signed [IN_W-1:0] arm_set [NUM_ARMS];
    logic signed [IN_W-1:0] set_max;
    logic signed [IN_W-1:0] set_min;
    logic signed [SW-1:0]   ext_sum;
    logic signed [SW-1:0]   ctrl_sum;
    logic signed [SW-1:0]   off_next;
    recentre_mode_e         mode_e;

    // Assemble the arm set; the slack arm starts at zero.
    always_comb begin
        arm_set[0]         = ref_a1;
        arm_set[1]         = ref_b1;
        arm_set[SLACK_IDX] = '0;
        arm_set[3]         = ref_b2;
    end

    // Find the most positive and the most negative member of the set.
    always_comb begin
        set_max = arm_set[0];
        set_min = arm_set[0];
        for (int i = 1; i < NUM_ARMS; i++) begin
            if (arm_set[i] > set_max) set_max = arm_set[i];
            if (arm_set[i] < set_min) set_min = arm_set[i];
        end
    end

    // Guard-bit sums; an arithmetic shift gives floor rounding.
    always_comb begin
        mode_e   = recentre_mode_e'(mode_sel);
        ext_sum  = SW'(set_max) + SW'(set_min);
        ctrl_sum = SW'(ref_a1) + SW'(ref_b1) + SW'(ref_b2);
        if (mode_e == MODE_ZERO_SUM) off_next = -(ctrl_sum >>> 2);
        else                         off_next = -(ext_sum >>> 1);
    end

    // Register the set and the offset on each accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_off   <= '0;
            for (int i = 0; i < NUM_ARMS; i++) s1_ref[i] <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_off <= off_next;
                for (int i = 0; i < NUM_ARMS; i++) s1_ref[i] <= arm_set[i];
            end
        end
    end

endmodule

// File: rtl/arm_sat_add.sv
// arm_sat_add: adds the common offset to one arm reference and saturates the
// result to the signed OUT_W range. Purely combinational.
// Assumes OUT_W <= IN_W + GUARD_W, so the guard-bit sum cannot overflow.
module arm_sat_add
    import arm_ref_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16,
    localparam int SW   = IN_W + GUARD_W
) (
    input  logic signed [IN_W-1:0]  ref_in,
    input  logic signed [SW-1:0]    offset,
    output logic signed [OUT_W-1:0] sat_out,
    output logic                    clipped
);

    localparam logic signed [SW-1:0] OMAX = {{(SW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [SW-1:0] OMIN = {{(SW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [SW-1:0] raw_sum;

    // Add in guard width, then clamp to the output range.
    always_comb begin
        raw_sum = SW'(ref_in) + offset;
        clipped = 1'b0;
        if (raw_sum > OMAX) begin
            sat_out = OMAX[OUT_W-1:0];
            clipped = 1'b1;
        end else if (raw_sum < OMIN) begin
            sat_out = OMIN[OUT_W-1:0];
            clipped = 1'b1;
        end else begin
            sat_out = raw_sum[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/ref_adjust.sv
// ref_adjust: second pipeline stage.
// Applies the offset to every arm through one saturating adder per arm,
// registers the results, and reports whether any arm clipped in this result.
// Outputs hold when no result is produced.
module ref_adjust
    import arm_ref_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16,
    localparam int SW   = IN_W + GUARD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  logic signed [IN_W-1:0]  s1_ref [NUM_ARMS],
    input  logic signed [SW-1:0]    s1_off,
    output logic                    s2_valid,
    output logic signed [OUT_W-1:0] s2_adj [NUM_ARMS],
    output logic                    s2_clip
);

    logic signed [OUT_W-1:0] sat_val [NUM_ARMS];
    logic [NUM_ARMS-1:0]     clip_vec;

    for (genvar g = 0; g < NUM_ARMS; g++) begin : g_arm
        arm_sat_add #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat (
            .ref_in  (s1_ref[g]),
            .offset  (s1_off),
            .sat_out (sat_val[g]),
            .clipped (clip_vec[g])
        );
    end

    // Register adjusted references and the per-result clip indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_clip  <= 1'b0;
            for (int i = 0; i < NUM_ARMS; i++) s2_adj[i] <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_clip  <= s1_valid && (|clip_vec);
            if (s1_valid) begin
                for (int i = 0; i < NUM_ARMS; i++) s2_adj[i] <= sat_val[i];
            end
        end
    end

endmodule

// File: rtl/arm_ref_recenter.sv
// arm_ref_recenter: top level.
// Takes three controller references, gives the slack arm a zero reference,
// re-centres all four with a common offset (centring or zero-sum mode),
// saturates them, and keeps a sticky clip flag. Fixed two-cycle latency.
// Assumes a synchronous active-low reset.
module arm_ref_recenter
    import arm_ref_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    mode_sel,
    input  logic signed [IN_W-1:0]  ref_a1,
    input  logic signed [IN_W-1:0]  ref_b1,
    input  logic signed [IN_W-1:0]  ref_b2,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] adj_a1,
    output logic signed [OUT_W-1:0] adj_b1,
    output logic signed [OUT_W-1:0] adj_a2,
    output logic signed [OUT_W-1:0] adj_b2,
    output logic                    clip_flag
);

    localparam int SW = IN_W + GUARD_W;

    logic                    s1_valid;
    logic signed [IN_W-1:0]  s1_ref [NUM_ARMS];
    logic signed [SW-1:0]    s1_off;
    logic                    s2_clip;
    logic signed [OUT_W-1:0] s2_adj [NUM_ARMS];
    logic                    clip_sticky;

    offset_calc #(.IN_W(IN_W)) u_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mode_sel (mode_sel),
        .ref_a1   (ref_a1),
        .ref_b1   (ref_b1),
        .ref_b2   (ref_b2),
        .s1_valid (s1_valid),
        .s1_ref   (s1_ref),
        .s1_off   (s1_off)
    );

    ref_adjust #(.IN_W(IN_W), .OUT_W(OUT_W)) u_adj (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_ref   (s1_ref),
        .s1_off   (s1_off),
        .s2_valid (out_valid),
        .s2_adj   (s2_adj),
        .s2_clip  (s2_clip)
    );

    // Sticky clip record, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) clip_sticky <= 1'b0;
        else if (s2_clip) clip_sticky <= 1'b1;
    end

    // Map the arm array onto the named output ports.
    always_comb begin
        adj_a1    = s2_adj[0];
        adj_b1    = s2_adj[1];
        adj_a2    = s2_adj[SLACK_IDX];
        adj_b2    = s2_adj[3];
        clip_flag = clip_sticky | s2_clip;
    end

endmodule

// File: rtl/arm_ref_recenter_chk.sv
// arm_ref_recenter_chk: assertion checker bound to arm_ref_recenter.
// Observes ports only; a cycle counter keeps $past lookups inside the
// cycles since reset.
module arm_ref_recenter_chk #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    mode_sel,
    input logic signed [IN_W-1:0]  ref_a1,
    input logic signed [IN_W-1:0]  ref_b1,
    input logic signed [IN_W-1:0]  ref_b2,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] adj_a1,
    input logic signed [OUT_W-1:0] adj_b1,
    input logic signed [OUT_W-1:0] adj_a2,
    input logic signed [OUT_W-1:0] adj_b2,
    input logic                    clip_flag
);

    localparam logic signed [OUT_W-1:0] RMAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] RMIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [1:0]              since_rst;
    logic signed [OUT_W+1:0] hi;
    logic signed [OUT_W+1:0] lo;
    logic signed [OUT_W+1:0] tot;
    logic                    at_rail;

    // Count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Balance figures of the output set.
    always_comb begin
        hi = (OUT_W+2)'(adj_a1);
        lo = (OUT_W+2)'(adj_a1);
        if ((OUT_W+2)'(adj_b1) > hi) hi = (OUT_W+2)'(adj_b1);
        if ((OUT_W+2)'(adj_a2) > hi) hi = (OUT_W+2)'(adj_a2);
        if ((OUT_W+2)'(adj_b2) > hi) hi = (OUT_W+2)'(adj_b2);
        if ((OUT_W+2)'(adj_b1) < lo) lo = (OUT_W+2)'(adj_b1);
        if ((OUT_W+2)'(adj_a2) < lo) lo = (OUT_W+2)'(adj_a2);
        if ((OUT_W+2)'(adj_b2) < lo) lo = (OUT_W+2)'(adj_b2);
        tot = (OUT_W+2)'(adj_a1) + (OUT_W+2)'(adj_b1)
            + (OUT_W+2)'(adj_a2) + (OUT_W+2)'(adj_b2);
        at_rail = (adj_a1 == RMAX) || (adj_a1 == RMIN) || (adj_b1 == RMAX) || (adj_b1 == RMIN)
               || (adj_a2 == RMAX) || (adj_a2 == RMIN) || (adj_b2 == RMAX) || (adj_b2 == RMIN);
    end

    AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2

    AST_LATENCY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst >= 2'd2) |-> $past(in_valid, 2)); // R2

    AST_CLIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(clip_flag)) |-> clip_flag); // R8

    AST_CLIP_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $rose(clip_flag)) |-> (out_valid && at_rail)); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !out_valid) |->
            ($stable(adj_a1) && $stable(adj_b1) && $stable(adj_a2) && $stable(adj_b2))); // R9

    AST_CENTRE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst >= 2'd2 && !$past(mode_sel, 2) && !at_rail)
            |-> ((hi + lo) == 0 || (hi + lo) == 1)); // R10

    AST_ZSUM_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst >= 2'd2 && $past(mode_sel, 2) && !at_rail)
            |-> (tot >= 0 && tot <= 3)); // R10

endmodule

bind arm_ref_recenter arm_ref_recenter_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/sim_arm_ref_recenter.sv
`timescale 1ns/1ps
// Directed bench for arm_ref_recenter; one task per scenario.
module sim_arm_ref_recenter;

    localparam int IN_W  = 16;
    localparam int OUT_W = 16;
    localparam int OMAX  = 32767;
    localparam int OMIN  = -32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic mode_sel = 1'b0;
    logic signed [IN_W-1:0] ref_a1 = '0;
    logic signed [IN_W-1:0] ref_b1 = '0;
    logic signed [IN_W-1:0] ref_b2 = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] adj_a1, adj_b1, adj_a2, adj_b2;
    logic clip_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit sticky_exp = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    arm_ref_recenter #(.IN_W(IN_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
        .ref_a1(ref_a1), .ref_b1(ref_b1), .ref_b2(ref_b2),
        .out_valid(out_valid), .adj_a1(adj_a1), .adj_b1(adj_b1),
        .adj_a2(adj_a2), .adj_b2(adj_b2), .clip_flag(clip_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp(input int v);
        if (v > OMAX) return OMAX;
        if (v < OMIN) return OMIN;
        return v;
    endfunction

    // Reference model: expected offset from the requirement formulas.
    function automatic int model_off(input int a, input int b, input int c, input bit m);
        int mx, mn, s;
        if (m) begin
            s = a + b + c;
            return -(s >>> 2);
        end
        mx = 0; mn = 0;
        if (a > mx) mx = a; if (b > mx) mx = b; if (c > mx) mx = c;
        if (a < mn) mn = a; if (b < mn) mn = b; if (c < mn) mn = c;
        s = mx + mn;
        return -(s >>> 1);
    endfunction

    task automatic drive(input int a, input int b, input int c, input bit m);
        ref_a1 = IN_W'(a); ref_b1 = IN_W'(b); ref_b2 = IN_W'(c); mode_sel = m;
        in_valid = 1'b1;
    endtask

    task automatic expect_result(input string req, input int a, input int b, input int c, input bit m);
        int off;
        bit clip;
        off  = model_off(a, b, c, m);
        clip = (clamp(a + off) != a + off) || (clamp(b + off) != b + off)
            || (clamp(off) != off) || (clamp(c + off) != c + off);
        if (clip) sticky_exp = 1'b1;
        check({req, " out_valid"}, int'(out_valid), 1);
        check({req, " adj_a1"}, int'(adj_a1), clamp(a + off));
        check({req, " adj_b1"}, int'(adj_b1), clamp(b + off));
        check({req, " adj_a2 (R3)"}, int'(adj_a2), clamp(off));
        check({req, " adj_b2"}, int'(adj_b2), clamp(c + off));
        check({req, " clip_flag (R8)"}, int'(clip_flag), int'(sticky_exp));
    endtask

    // One transaction: valid for one cycle, result sampled two edges later.
    task automatic run_one(input string req, input int a, input int b, input int c, input bit m);
        @(negedge clk); drive(a, b, c, m);
        @(negedge clk); in_valid = 1'b0;
        check({req, " R2 no early valid"}, int'(out_valid), 0);
        @(negedge clk); expect_result(req, a, b, c, m);
        @(negedge clk);
        check({req, " R2 single valid"}, int'(out_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 adj_a1", int'(adj_a1), 0);
        check("R1 adj_b1", int'(adj_b1), 0);
        check("R1 adj_a2", int'(adj_a2), 0);
        check("R1 adj_b2", int'(adj_b2), 0);
        check("R1 clip_flag", int'(clip_flag), 0);
    endtask

    task automatic t_centre();
        run_one("R4 centre mixed", 100, -50, 30, 1'b0);
        run_one("R4 centre odd pos", 7, 0, 0, 1'b0);
        run_one("R4 centre odd neg", -7, 0, 0, 1'b0);
        run_one("R4 centre all pos", 200, 150, 90, 1'b0);
    endtask

    task automatic t_zero_sum();
        run_one("R5 zsum even", 10, 20, 30, 1'b1);
        run_one("R5 zsum round pos", 1, 1, 1, 1'b1);
        run_one("R5 zsum round neg", -1, 0, 0, 1'b1);
        run_one("R5 zsum neg", -300, -125, 40, 1'b1);
    endtask

    // R6: a mode change outside a valid cycle must not alter the next result.
    task automatic t_mode_ignored();
        @(negedge clk); mode_sel = 1'b1; in_valid = 1'b0;
        @(negedge clk); mode_sel = 1'b1;
        @(negedge clk); drive(100, -50, 30, 1'b0);
        @(negedge clk); in_valid = 1'b0; mode_sel = 1'b1;
        @(negedge clk); expect_result("R6 mode sampled on valid", 100, -50, 30, 1'b0);
    endtask

    // R9: outputs hold while no valid arrives, whatever the inputs do.
    task automatic t_hold();
        int pa1, pb1, pa2, pb2;
        run_one("R9 setup", 40, -20, 10, 1'b0);
        pa1 = adj_a1; pb1 = adj_b1; pa2 = adj_a2; pb2 = adj_b2;
        ref_a1 = 16'sd999; ref_b1 = -16'sd999; ref_b2 = 16'sd5; mode_sel = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 out_valid low", int'(out_valid), 0);
        check("R9 hold a1", int'(adj_a1), pa1);
        check("R9 hold b1", int'(adj_b1), pb1);
        check("R9 hold a2", int'(adj_a2), pa2);
        check("R9 hold b2", int'(adj_b2), pb2);
    endtask

    // R2: back-to-back inputs produce back-to-back results.
    task automatic t_back_to_back();
        @(negedge clk); drive(12, -4, 6, 1'b0);
        @(negedge clk); drive(-9, 3, 3, 1'b1);
        @(negedge clk); in_valid = 1'b0;
        expect_result("R2 b2b first", 12, -4, 6, 1'b0);
        @(negedge clk); expect_result("R2 b2b second", -9, 3, 3, 1'b1);
        @(negedge clk); check("R2 b2b end", int'(out_valid), 0);
    endtask

    // R7/R8: saturation in both modes, then stickiness on a clean result.
    task automatic t_saturate();
        run_one("R7 centre clip", 32767, -32768, -32768, 1'b0);
        run_one("R7 zsum clip", 32767, -32768, -32768, 1'b1);
        run_one("R8 sticky after clean", 5, 5, 5, 1'b0);
        check("R8 flag held", int'(clip_flag), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_centre();
        t_zero_sum();
        t_mode_ignored();
        t_hold();
        t_back_to_back();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule